// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a cluster of small control registers for an auxiliary I/O controller. Software reaches it through a simple register port: select, write enable, address, access size and write data, with combinational read data. It holds five byte-wide registers (configuration, diagnostic, modem control, a miscellaneous-functions register and a software power-down register), a 16-bit LED register and a 32-bit system-control register.

Some bits act on the outside world. A write to the miscellaneous-functions register can fire a one-cycle terminal-count pulse toward a floppy controller. The power-down register carries a sticky power-fail flag. The flag is set from a power-fail input only while the configuration register enables it. Software clears the flag with a write-to-clear bit, and a power-off bit in the same register raises a power-off request. A reset command in the system-control register raises a reset request and leaves a status value behind. The interrupt output reflects the enabled power-fail flag. Reset clears only part of the register set, so the diagnostic, system-control and LED contents survive a reset.

Top module: `aux_ctl_regs`

## Requirements
- R1: A byte write to the miscellaneous-functions register (address 3) with data bit 1 set produces `tc_pulse_o` high for exactly the one cycle after the write edge. Bit 1 is never stored and reads back 0. The other seven bits are stored as written.
- R2: A byte write to the power-down register (address 4) accepts only data bits 0 (power-off) and 1 (flag clear). The power-fail flag in bit 5 keeps its current value across the write. All other bits read 0.
- R3: When a power-down write has bit 1 set, the stored value keeps only bit 0. The power-fail flag (bit 5) is cleared, and bit 1 is not stored.
- R4: `pwr_off_req_o` is high for exactly the one cycle after any power-down write that leaves bit 0 stored as 1. Otherwise it is low.
- R5: When `pwr_fail_i` differs from its value in the previous cycle, the flag becomes `pwr_fail_i` AND configuration bit 3, with both sampled in that cycle. Without such a change the input has no effect. When a change and a power-down write fall in the same cycle, the change decides bit 5.
- R6: `irq_o` is high exactly when power-down bit 5 and configuration bit 3 are both set. Clearing configuration bit 3 drops `irq_o` but keeps the flag.
- R7: A word write to the system-control register (address 8) with data bit 0 set loads the register with 0x02 and pulses `sys_rst_req_o` for one cycle. A write with bit 0 clear changes nothing. Word reads at addresses 9 to 11 return 0.
- R8: Reset clears the configuration, miscellaneous-functions, power-down and modem-control registers and all pulse outputs. The diagnostic, system-control and LED registers keep their contents.
- R9: Access sizes are encoded on `bus_size` as 0 = byte, 1 = half-word and 2 = word. Byte registers accept only byte, the LED register (address 5) only half-word, and system control only word. A wrong-size write changes nothing, and a wrong-size read returns 0.
- R10: Configuration (address 0), diagnostic (address 1), modem control (address 2) and LED (address 5) are plain storage. They read back exactly what was last written.
- R11: Reads at addresses outside the map (6, 7, 9 to 15) return 0, and reads with `bus_sel` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero-extended |
| pwr_fail_i | input | 1 | Power-fail level, already synchronous to clk |
| irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | One-cycle terminal-count pulse |
| pwr_off_req_o | output | 1 | One-cycle power-off request |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions take `pwr_fail_i` to be a clean level that is already synchronous to the clock. They also take every access to be a single-cycle strobe whose size and address are stable for that cycle. The stimulus changes inputs only on the falling edge. It moves the power-fail level only in cycles with no bus access, except in the one case built to test a level change and a power-down write in the same cycle. The diagnostic and system-control registers are never reset, so the stimulus writes them before any read or assertion depends on their value.

// File: rtl/aux_ctl_pkg.sv
`timescale 1ns/1ps
package aux_ctl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned NREG     = 7;
  localparam int unsigned IDX_CFG  = 0;
  localparam int unsigned IDX_DIAG = 1;
  localparam int unsigned IDX_MDM  = 2;
  localparam int unsigned IDX_MISC = 3;
  localparam int unsigned IDX_PDN  = 4;
  localparam int unsigned IDX_LED  = 5;
  localparam int unsigned IDX_SYS  = 6;

  // Register address and required access size, indexed by IDX_*
  localparam int unsigned REG_ADDR [NREG] = '{0, 1, 2, 3, 4, 5, 8};
  localparam logic [1:0]  REG_SIZE [NREG] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2};

  // Bit positions with behaviour attached
  localparam int unsigned CFG_PF_EN_BIT = 3;
  localparam int unsigned MISC_TC_BIT   = 1;
  localparam int unsigned PDN_OFF_BIT   = 0;
  localparam int unsigned PDN_CLR_BIT   = 1;
  localparam int unsigned PDN_FAIL_BIT  = 5;
  localparam int unsigned SYS_GO_BIT    = 0;
  localparam logic [7:0]  SYS_STATUS    = 8'h02;

endpackage

// File: rtl/aux_ctl_decode.sv
`timescale 1ns/1ps
module aux_ctl_decode
  import aux_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [NREG-1:0]   hit
);

  // One comparator pair per register: address match and legal size
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(REG_ADDR[i])) && (size == REG_SIZE[i]);
  end

endmodule

// File: rtl/aux_ctl_field.sv
`timescale 1ns/1ps
module aux_ctl_field #(
  parameter int unsigned W       = 8,
  parameter bit          HAS_RST = 1'b1,
  parameter logic [W-1:0] KEEP   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         unused_rst;

  assign unused_rst = rst_n;

  always_comb begin
    q_nxt = q;
    if (we) begin
      q_nxt = wdata & KEEP;
    end
  end

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        q <= q_nxt;
      end
    end
  end else begin : g_keep
    always_ff @(posedge clk) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/aux_ctl_pwr.sv
`timescale 1ns/1ps
module aux_ctl_pwr
  import aux_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wbits,
  input  logic       cfg_en,
  input  logic       pf_lvl,
  output logic [7:0] pdn_q,
  output logic       irq,
  output logic       off_req
);

  logic [7:0] wr_val;
  logic [7:0] pdn_nxt;
  logic       pf_prev;
  logic       pf_evt;
  logic       off_nxt;

  assign pf_evt = pf_lvl ^ pf_prev;

  always_comb begin
    wr_val = 8'h00;
    wr_val[PDN_OFF_BIT]  = wbits[0];
    wr_val[PDN_CLR_BIT]  = wbits[1];
    wr_val[PDN_FAIL_BIT] = pdn_q[PDN_FAIL_BIT];
    if (wr_val[PDN_CLR_BIT]) begin
      wr_val = wr_val & (8'h01 << PDN_OFF_BIT);
    end

    pdn_nxt = pdn_q;
    if (we) begin
      pdn_nxt = wr_val;
    end
    if (pf_evt) begin
      pdn_nxt[PDN_FAIL_BIT] = pf_lvl & cfg_en;
    end

    off_nxt = we & wr_val[PDN_OFF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q   <= 8'h00;
      pf_prev <= 1'b0;
      off_req <= 1'b0;
    end else begin
      pdn_q   <= pdn_nxt;
      pf_prev <= pf_lvl;
      off_req <= off_nxt;
    end
  end

  assign irq = pdn_q[PDN_FAIL_BIT] & cfg_en;

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdn_q[PDN_FAIL_BIT]) |-> $past(cfg_en) && $past(pf_lvl)); // R5

  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wbits[1] && !pf_evt) |=> !pdn_q[PDN_FAIL_BIT] && !pdn_q[PDN_CLR_BIT]); // R3

  AST_OFF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> $past(we) && pdn_q[PDN_OFF_BIT]); // R4

endmodule

// File: rtl/aux_ctl_sys.sv
`timescale 1ns/1ps
module aux_ctl_sys
  import aux_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       go_bit,
  output logic [7:0] stat_q,
  output logic       rst_req
);

  logic [7:0] stat_nxt;
  logic       req_nxt;

  always_comb begin
    req_nxt  = we & go_bit;
    stat_nxt = stat_q;
    if (req_nxt) begin
      stat_nxt = SYS_STATUS;
    end
  end

  // Status survives reset on purpose
  always_ff @(posedge clk) begin
    stat_q <= stat_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= req_nxt;
    end
  end

  AST_REQ_LEAVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> stat_q == SYS_STATUS); // R7

endmodule

// File: rtl/aux_ctl_regs.sv
`timescale 1ns/1ps
module aux_ctl_regs
  import aux_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_pulse_o,
  output logic              pwr_off_req_o,
  output logic              sys_rst_req_o
);

  localparam logic [BYTE_W-1:0] MISC_KEEP = ~(BYTE_W'(1) << MISC_TC_BIT);

  logic [NREG-1:0]   acc_hit;
  logic [NREG-1:0]   wr_hit;
  logic [NREG-1:0]   rd_hit;
  logic [BYTE_W-1:0] cfg_q;
  logic [BYTE_W-1:0] diag_q;
  logic [BYTE_W-1:0] mdm_q;
  logic [BYTE_W-1:0] misc_q;
  logic [7:0]        pdn_q;
  logic [LED_W-1:0]  led_q;
  logic [7:0]        sys_q;
  logic              tc_nxt;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:LED_W];

  aux_ctl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .size (bus_size),
    .hit  (acc_hit)
  );

  assign wr_hit = acc_hit & {NREG{bus_sel &  bus_we}};
  assign rd_hit = acc_hit & {NREG{bus_sel & ~bus_we}};

  aux_ctl_field #(.W(BYTE_W), .HAS_RST(1'b1)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_CFG]),
    .wdata(bus_wdata[BYTE_W-1:0]), .q(cfg_q)
  );

  aux_ctl_field #(.W(BYTE_W), .HAS_RST(1'b0)) i_diag (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_DIAG]),
    .wdata(bus_wdata[BYTE_W-1:0]), .q(diag_q)
  );

  aux_ctl_field #(.W(BYTE_W), .HAS_RST(1'b1)) i_mdm (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_MDM]),
    .wdata(bus_wdata[BYTE_W-1:0]), .q(mdm_q)
  );

  aux_ctl_field #(.W(BYTE_W), .HAS_RST(1'b1), .KEEP(MISC_KEEP)) i_misc (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_MISC]),
    .wdata(bus_wdata[BYTE_W-1:0]), .q(misc_q)
  );

  aux_ctl_field #(.W(LED_W), .HAS_RST(1'b0)) i_led (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[IDX_LED]),
    .wdata(bus_wdata[LED_W-1:0]), .q(led_q)
  );

  aux_ctl_pwr i_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_hit[IDX_PDN]),
    .wbits   (bus_wdata[1:0]),
    .cfg_en  (cfg_q[CFG_PF_EN_BIT]),
    .pf_lvl  (pwr_fail_i),
    .pdn_q   (pdn_q),
    .irq     (irq_o),
    .off_req (pwr_off_req_o)
  );

  aux_ctl_sys i_sys (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_hit[IDX_SYS]),
    .go_bit  (bus_wdata[SYS_GO_BIT]),
    .stat_q  (sys_q),
    .rst_req (sys_rst_req_o)
  );

  // Terminal-count strobe
  assign tc_nxt = wr_hit[IDX_MISC] & bus_wdata[MISC_TC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_pulse_o <= 1'b0;
    end else begin
      tc_pulse_o <= tc_nxt;
    end
  end

  // Read mux, zero-extended
  always_comb begin
    bus_rdata = '0;
    if (rd_hit[IDX_CFG])  bus_rdata[BYTE_W-1:0] = cfg_q;
    if (rd_hit[IDX_DIAG]) bus_rdata[BYTE_W-1:0] = diag_q;
    if (rd_hit[IDX_MDM])  bus_rdata[BYTE_W-1:0] = mdm_q;
    if (rd_hit[IDX_MISC]) bus_rdata[BYTE_W-1:0] = misc_q;
    if (rd_hit[IDX_PDN])  bus_rdata[7:0]        = pdn_q;
    if (rd_hit[IDX_LED])  bus_rdata[LED_W-1:0]  = led_q;
    if (rd_hit[IDX_SYS])  bus_rdata[7:0]        = sys_q;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_hit)); // R11

  AST_TC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(3) && bus_size == SZ_BYTE && bus_wdata[MISC_TC_BIT])
    |=> tc_pulse_o && !misc_q[MISC_TC_BIT]); // R1

  AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(0) && bus_size != SZ_BYTE) |=> $stable(cfg_q)); // R9

  AST_NO_SEL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0); // R11

endmodule

// File: tb/test_aux_ctl_regs.sv
`timescale 1ns/1ps
module test_aux_ctl_regs;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwr_fail_i;
  logic        irq_o;
  logic        tc_pulse_o;
  logic        pwr_off_req_o;
  logic        sys_rst_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  string       exp_tag_q[$];
  logic [31:0] exp_val_q[$];

  aux_ctl_regs i_aux_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwr_fail_i(pwr_fail_i), .irq_o(irq_o),
    .tc_pulse_o(tc_pulse_o), .pwr_off_req_o(pwr_off_req_o),
    .sys_rst_req_o(sys_rst_req_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: one-cycle strobe driven on the falling edge
  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] sz,
                    input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    exp_tag_q.push_back(tag);
    exp_val_q.push_back(exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Called right after wr(): samples the cycle after the write edge, then the next
  task automatic pulses(input string tag, input bit tc, input bit off, input bit rq);
    #3;
    chk({tag, " pulse tc"},  32'(tc_pulse_o),    32'(tc));
    chk({tag, " pulse off"}, 32'(pwr_off_req_o), 32'(off));
    chk({tag, " pulse rst"}, 32'(sys_rst_req_o), 32'(rq));
    @(negedge clk); #3;
    chk({tag, " pulse gone"}, {29'd0, tc_pulse_o, pwr_off_req_o, sys_rst_req_o}, 32'd0);
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk);
    pwr_fail_i = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk); #3;
    chk(tag, 32'(irq_o), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: pops expected read data and compares
  initial begin
    forever begin
      @(negedge clk); #3;
      if (bus_sel && !bus_we) begin
        if (exp_val_q.size() == 0) begin
          chk("R11 unexpected read", bus_rdata, 32'hDEAD_BEEF);
        end else begin
          chk(exp_tag_q.pop_front(), bus_rdata, exp_val_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_size = 2'd0; bus_wdata = '0; pwr_fail_i = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk("R8 outputs in reset", {28'd0, irq_o, tc_pulse_o, pwr_off_req_o, sys_rst_req_o}, 32'd0);
    rst_n = 1'b1;

    rd("R8 cfg after reset",   4'd0, 2'd0, 32'h0);
    rd("R8 modem after reset", 4'd2, 2'd0, 32'h0);
    rd("R8 misc after reset",  4'd3, 2'd0, 32'h0);
    rd("R8 pdn after reset",   4'd4, 2'd0, 32'h0);

    // R10 plain storage
    wr(4'd0, 2'd0, 32'h0000_00A5); rd("R10 cfg",   4'd0, 2'd0, 32'hA5);
    wr(4'd1, 2'd0, 32'h0000_003C); rd("R10 diag",  4'd1, 2'd0, 32'h3C);
    wr(4'd2, 2'd0, 32'h0000_0081); rd("R10 modem", 4'd2, 2'd0, 32'h81);
    wr(4'd5, 2'd1, 32'h1234_BEEF); rd("R10 led",   4'd5, 2'd1, 32'hBEEF);

    // R9 size rules
    wr(4'd0, 2'd1, 32'h0000_00FF); rd("R9 cfg half write ignored", 4'd0, 2'd0, 32'hA5);
    rd("R9 cfg word read zero", 4'd0, 2'd2, 32'h0);
    wr(4'd5, 2'd0, 32'h0000_0011); rd("R9 led byte write ignored", 4'd5, 2'd1, 32'hBEEF);
    rd("R9 led word read zero", 4'd5, 2'd2, 32'h0);

    // R1 terminal count
    wr(4'd3, 2'd0, 32'h0000_00FF); pulses("R1 tc write", 1'b1, 1'b0, 1'b0);
    rd("R1 misc bit1 not stored", 4'd3, 2'd0, 32'hFD);
    wr(4'd3, 2'd0, 32'h0000_0040); pulses("R1 no tc", 1'b0, 1'b0, 1'b0);
    rd("R1 misc plain", 4'd3, 2'd0, 32'h40);
    wr(4'd3, 2'd1, 32'h0000_0002); pulses("R9 tc wrong size", 1'b0, 1'b0, 1'b0);

    // R5/R6 power fail with enable
    wr(4'd0, 2'd0, 32'h0000_0008);
    set_pf(1'b1);
    rd("R5 flag set", 4'd4, 2'd0, 32'h20);
    chk_irq("R6 irq high", 1'b1);
    wr(4'd4, 2'd0, 32'h0000_00FC); pulses("R2 masked write", 1'b0, 1'b0, 1'b0);
    rd("R2 only bits 0,1 taken, flag kept", 4'd4, 2'd0, 32'h20);
    wr(4'd4, 2'd0, 32'h0000_0001); pulses("R4 power off", 1'b0, 1'b1, 1'b0);
    rd("R2 off bit with flag", 4'd4, 2'd0, 32'h21);
    chk_irq("R6 irq still high", 1'b1);
    wr(4'd4, 2'd0, 32'h0000_0002); pulses("R3 clear no off", 1'b0, 1'b0, 1'b0);
    rd("R3 flag cleared", 4'd4, 2'd0, 32'h00);
    chk_irq("R6 irq low after clear", 1'b0);
    wr(4'd4, 2'd0, 32'h0000_0023);
    rd("R3 clear keeps off bit", 4'd4, 2'd0, 32'h01);
    chk_irq("R5 steady level no effect", 1'b0);

    // R5 without enable
    set_pf(1'b0);
    wr(4'd0, 2'd0, 32'h0000_0000);
    set_pf(1'b1);
    rd("R5 no flag without enable", 4'd4, 2'd0, 32'h01);
    wr(4'd0, 2'd0, 32'h0000_0008);
    chk_irq("R6 enable alone no irq", 1'b0);

    // R6 enable gating of an existing flag
    set_pf(1'b0);
    set_pf(1'b1);
    chk_irq("R6 irq after re-fail", 1'b1);
    wr(4'd0, 2'd0, 32'h0000_0000);
    chk_irq("R6 irq drops with enable", 1'b0);
    rd("R6 flag kept", 4'd4, 2'd0, 32'h21);
    wr(4'd0, 2'd0, 32'h0000_0008);
    chk_irq("R6 irq back", 1'b1);

    // R5 level change in same cycle as a clearing write: change wins
    @(negedge clk);
    pwr_fail_i = 1'b0;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_size = 2'd0; bus_wdata = 32'h0;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    pwr_fail_i = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_size = 2'd0; bus_wdata = 32'h2;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd("R5 change beats clear", 4'd4, 2'd0, 32'h20);

    // R7 system control
    wr(4'd8, 2'd2, 32'h0000_0000); pulses("R7 no go", 1'b0, 1'b0, 1'b0);
    wr(4'd8, 2'd2, 32'h0000_0001); pulses("R7 go", 1'b0, 1'b0, 1'b1);
    rd("R7 status", 4'd8, 2'd2, 32'h02);
    rd("R7 other offset", 4'd9, 2'd2, 32'h0);
    wr(4'd8, 2'd0, 32'h0000_0001); pulses("R9 sys byte write", 1'b0, 1'b0, 1'b0);

    // R11 unmapped
    rd("R11 addr 7", 4'd7, 2'd0, 32'h0);
    rd("R11 addr 15", 4'd15, 2'd2, 32'h0);

    // R8 partial reset
    set_pf(1'b0);
    do_reset();
    rd("R8 cfg cleared",   4'd0, 2'd0, 32'h0);
    rd("R8 diag kept",     4'd1, 2'd0, 32'h3C);
    rd("R8 modem cleared", 4'd2, 2'd0, 32'h0);
    rd("R8 misc cleared",  4'd3, 2'd0, 32'h0);
    rd("R8 pdn cleared",   4'd4, 2'd0, 32'h0);
    rd("R8 led kept",      4'd5, 2'd1, 32'hBEEF);
    rd("R8 sys kept",      4'd8, 2'd2, 32'h02);
    chk_irq("R8 irq low", 1'b0);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", 32'(exp_val_q.size()), 32'd0);
    finish_run();
  end

endmodule